// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Almost-Empty Flag

This block is a single-clock first-in first-out buffer for 18-bit words with a parameterized depth of 512 words by default. A word is accepted on each clock edge where the write enable is high and the buffer has room. A word is removed on each edge where the read enable is high and the buffer holds data. The removed word appears on a registered output after that edge. Reads into an empty buffer and writes into a full buffer are ignored.

Three active-low status outputs describe the fill level. The empty flag is low while no word is stored. A second empty flag repeats the first one clock later. The almost-empty flag is low while the stored count is at or below a programmable threshold. The threshold starts at one eighth of the depth minus one and can be reloaded with a single-cycle strobe. A mode pin is sampled while reset is held. It selects whether the almost-empty flag follows the count in the same cycle, or comes from a register that lags the count by one clock.

Top module: `ae_fifo`

## Requirements
- R1: While and after reset, with no write since, `empty_n`, `empty_dly_n`, `almost_empty_n` and `rd_data` are all 0, and the threshold is DEPTH/8-1 (63 at the default depth).
- R2: Accepted words leave in the order they entered. `rd_data` changes only on an edge that accepts a read, and then shows the oldest stored word.
- R3: A read request while the buffer is empty is ignored: `rd_data` keeps its value and the stored count does not change.
- R4: A write request while DEPTH words are stored is ignored, even if a read is accepted on the same edge. The dropped word never appears on `rd_data`.
- R5: `empty_n` is 0 exactly when the stored count is zero. It changes on the edge that changes the count.
- R6: `empty_dly_n` equals the value `empty_n` had one clock earlier.
- R7: In immediate mode (mode pin 0 during reset), `almost_empty_n` is 0 exactly when the current count is less than or equal to the current threshold.
- R8: In registered mode (mode pin 1 during reset), `almost_empty_n` equals the immediate-mode value of the previous cycle.
- R9: An edge with `thr_load` high sets the threshold to `thr_value`. A value greater than DEPTH is stored as DEPTH.
- R10: The mode pin is sampled only while `rst_n` is low. Changing it afterwards has no effect.
- R11: On a non-empty, non-full buffer, an edge that accepts both a read and a write leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ae_sync | input | 1 | Almost-empty update mode, sampled during reset (0 immediate, 1 registered) |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read, registered |
| thr_load | input | 1 | Threshold load strobe |
| thr_value | input | $clog2(DEPTH)+1 | New threshold value |
| empty_n | output | 1 | Empty flag, active low |
| empty_dly_n | output | 1 | Empty flag delayed by one clock, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench fills the buffer to exactly DEPTH words and keeps writing, with and without a simultaneous read. A design that let the pointers wrap would then return an overwritten word or report the buffer as empty. It reads repeatedly while empty to catch a read that slips through and moves `rd_data` or the read pointer. It walks the count across the default threshold of 63 and across loaded thresholds of 0, DEPTH and over-range values. An off-by-one compare or a missing clamp moves the flag edge by a word. In registered mode it checks the one-cycle lag, and it toggles the mode pin after reset to expose a design that keeps sampling it.

// File: rtl/ae_fifo_pkg.sv
package ae_fifo_pkg;
   typedef enum logic {
      AE_IMMEDIATE  = 1'b0,
      AE_REGISTERED = 1'b1
   } ae_mode_e;

   function automatic int unsigned default_threshold(input int unsigned depth);
      return depth / 8 - 1;
   endfunction
endpackage

// File: rtl/ae_fifo_store.sv
module ae_fifo_store #(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 512,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_ok,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem_q[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_ok) begin
         rdata <= mem_q[raddr];
      end
   end
endmodule

// File: rtl/ae_fifo_ptr.sv
module ae_fifo_ptr #(
   parameter int DEPTH = 512,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              rd_req,
   output logic              wr_ok,
   output logic              rd_ok,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W-1:0] raddr,
   output logic [CNT_W-1:0]  fill,
   output logic              is_empty
);
   logic [CNT_W-1:0] wptr_q, rptr_q;
   logic             is_full;

   assign is_empty = (wptr_q == rptr_q);
   assign is_full  = (wptr_q[ADDR_W] != rptr_q[ADDR_W]) &&
                     (wptr_q[ADDR_W-1:0] == rptr_q[ADDR_W-1:0]);
   assign rd_ok    = rd_req && !is_empty;
   assign wr_ok    = wr_req && !is_full;
   assign waddr    = wptr_q[ADDR_W-1:0];
   assign raddr    = rptr_q[ADDR_W-1:0];
   assign fill     = wptr_q - rptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (wr_ok) wptr_q <= wptr_q + CNT_W'(1);
         if (rd_ok) rptr_q <= rptr_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ae_fifo_flags.sv
module ae_fifo_flags
   import ae_fifo_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int CNT_W = $clog2(DEPTH) + 1,
   localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(default_threshold(DEPTH)),
   localparam logic [CNT_W-1:0] THR_MAX   = CNT_W'(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_pin,
   input  logic [CNT_W-1:0] fill,
   input  logic             is_empty,
   input  logic             thr_load,
   input  logic [CNT_W-1:0] thr_value,
   output logic             empty_n,
   output logic             empty_dly_n,
   output logic             almost_empty_n,
   output logic [CNT_W-1:0] thr_q,
   output ae_mode_e         mode_q
);
   logic ae_now_n;
   logic ae_reg_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= ae_mode_e'(mode_pin);
         thr_q  <= THR_RESET;
      end else if (thr_load) begin
         thr_q  <= (thr_value > THR_MAX) ? THR_MAX : thr_value;
      end
   end

   assign empty_n  = !is_empty;
   assign ae_now_n = !(fill <= thr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_dly_n <= 1'b0;
         ae_reg_n    <= 1'b0;
      end else begin
         empty_dly_n <= empty_n;
         ae_reg_n    <= ae_now_n;
      end
   end

   assign almost_empty_n = (mode_q == AE_REGISTERED) ? ae_reg_n : ae_now_n;
endmodule

// File: rtl/ae_fifo.sv
module ae_fifo
   import ae_fifo_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 512,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ae_sync,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              thr_load,
   input  logic [CNT_W-1:0]  thr_value,
   output logic              empty_n,
   output logic              empty_dly_n,
   output logic              almost_empty_n
);
   initial begin
      if (DATA_W < 1) $error("ae_fifo: DATA_W must be at least 1");
      if (DEPTH < 8) $error("ae_fifo: DEPTH must be at least 8");
      if ((1 << ADDR_W) != DEPTH) $error("ae_fifo: DEPTH must be a power of two");
   end

   logic              wr_ok, rd_ok, is_empty;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [CNT_W-1:0]  fill, thr_q;
   ae_mode_e          mode_q;

   ae_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
      .wr_ok(wr_ok), .rd_ok(rd_ok), .waddr(waddr), .raddr(raddr),
      .fill(fill), .is_empty(is_empty)
   );

   ae_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .waddr(waddr), .wdata(wr_data),
      .rd_ok(rd_ok), .raddr(raddr), .rdata(rd_data)
   );

   ae_fifo_flags #(.DEPTH(DEPTH)) u_flags (
      .clk(clk), .rst_n(rst_n), .mode_pin(ae_sync), .fill(fill),
      .is_empty(is_empty), .thr_load(thr_load), .thr_value(thr_value),
      .empty_n(empty_n), .empty_dly_n(empty_dly_n),
      .almost_empty_n(almost_empty_n), .thr_q(thr_q), .mode_q(mode_q)
   );
endmodule

// File: rtl/ae_fifo_chk.sv
module ae_fifo_chk #(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 512,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              empty_n,
   input logic              empty_dly_n,
   input logic              almost_empty_n,
   input logic [CNT_W-1:0]  fill,
   input logic [CNT_W-1:0]  thr_q,
   input logic              mode_q
);
   // R3
   empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && rd_en) |=> $stable(rd_data));
   // R3
   empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !wr_en) |=> !empty_n);
   // R6
   empty_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty_dly_n == $past(empty_n));
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CNT_W'(DEPTH) && wr_en && !rd_en) |=> $stable(fill));
   // R11
   rw_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_n && rd_en && wr_en && fill != CNT_W'(DEPTH)) |=> $stable(fill));
   // R7
   imm_empty_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !empty_n) |-> !almost_empty_n);
   // R8
   reg_empty_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !empty_n) |=> !almost_empty_n);
   // R9
   thr_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_q <= CNT_W'(DEPTH));
endmodule

bind ae_fifo ae_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
   .empty_n(empty_n), .empty_dly_n(empty_dly_n), .almost_empty_n(almost_empty_n),
   .fill(fill), .thr_q(thr_q), .mode_q(mode_q)
);

// File: tb/ae_fifo_tb.sv
`timescale 1ns/1ps
module ae_fifo_tb;
   localparam int DW = 18;
   localparam int DEPTH = 512;
   localparam int CW = $clog2(DEPTH) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ae_sync = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, thr_load = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [CW-1:0] thr_value = '0;
   logic [DW-1:0] rd_data;
   logic empty_n, empty_dly_n, almost_empty_n;

   always #2 clk = ~clk;

   ae_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .ae_sync(ae_sync), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .thr_load(thr_load), .thr_value(thr_value),
      .empty_n(empty_n), .empty_dly_n(empty_dly_n), .almost_empty_n(almost_empty_n)
   );

   int n_cmp = 0, n_bad = 0;
   int q[$];
   int thr;
   int mode;
   int exp_rd;
   logic done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ae_value(input int cnt, input int t);
      return (cnt <= t) ? 0 : 1;
   endfunction

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst_n = 1'b0; ae_sync = m; wr_en = 0; rd_en = 0; thr_load = 0;
      repeat (2) @(negedge clk);
      q.delete(); thr = DEPTH / 8 - 1; mode = m; exp_rd = 0;
      chk("R1 empty_n", empty_n, 0);
      chk("R1 empty_dly_n", empty_dly_n, 0);
      chk("R1 almost_empty_n", almost_empty_n, 0);
      chk("R1 rd_data", rd_data, 0);
      rst_n = 1'b1;
   endtask

   task automatic step(input logic w, input int d, input logic r,
                       input logic ld, input int lv, input string dtag);
      int pc, pt, pe;
      bit rok, wok;
      @(negedge clk);
      wr_en = w; wr_data = DW'(d); rd_en = r; thr_load = ld; thr_value = CW'(lv);
      pc = q.size(); pt = thr; pe = (pc != 0);
      rok = r && pc > 0;
      wok = w && pc < DEPTH;
      @(posedge clk);
      #1;
      if (rok) exp_rd = q.pop_front();
      if (wok) q.push_back(d & ((1 << DW) - 1));
      if (ld) thr = (lv > DEPTH) ? DEPTH : lv;
      chk("R5 empty_n", empty_n, q.size() != 0);
      chk("R6 empty_dly_n", empty_dly_n, pe);
      if (r && pc == 0) chk("R3 rd_data held", rd_data, exp_rd);
      else chk(dtag, rd_data, exp_rd);
      if (ae_sync != mode[0])
         chk("R10 mode pin ignored", almost_empty_n,
             mode ? ae_value(pc, pt) : ae_value(q.size(), thr));
      else if (mode) chk("R8 registered flag", almost_empty_n, ae_value(pc, pt));
      else if (rok && wok) chk("R11 count kept", almost_empty_n, ae_value(q.size(), thr));
      else if (ld) chk("R9 loaded threshold", almost_empty_n, ae_value(q.size(), thr));
      else chk("R7 immediate flag", almost_empty_n, ae_value(q.size(), thr));
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      do_reset(1'b0);
      // R3: reads while empty
      for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R3 data");
      // R1: default threshold 63 in immediate mode
      for (int i = 0; i < 63; i++) step(1, i + 100, 0, 0, 0, "R2 data");
      chk("R1 ae at 63 words", almost_empty_n, 0);
      step(1, 163, 0, 0, 0, "R2 data");
      chk("R1 ae at 64 words", almost_empty_n, 1);
      // R11: balanced traffic at the threshold edge
      for (int i = 0; i < 10; i++) step(1, 200 + i, 1, 0, 0, "R11 data");
      // fill to full, then overflow attempts (R4)
      while (q.size() < DEPTH) step(1, $urandom, 0, 0, 0, "R2 data");
      for (int i = 0; i < 5; i++) step(1, 32'h3ffff - i, 0, 0, 0, "R4 data");
      step(1, 12345, 1, 0, 0, "R4 data");
      while (q.size() > 0) step(0, 0, 1, 0, 0, "R4 drained data");
      step(0, 0, 1, 0, 0, "R3 data");
      // R9: threshold loads including over-range and zero
      step(0, 0, 0, 1, DEPTH + 100, "R2 data");
      step(1, 7, 0, 0, 0, "R2 data");
      step(0, 0, 0, 1, 0, "R2 data");
      step(1, 8, 0, 0, 0, "R2 data");
      step(0, 0, 0, 1, 1, "R2 data");
      step(0, 0, 1, 0, 0, "R2 data");
      step(0, 0, 1, 0, 0, "R2 data");
      // random traffic, immediate mode
      for (int i = 0; i < 3000; i++) begin
         int bias = (i / 500) % 2 ? 80 : 30;
         step($urandom_range(0, 99) < bias, $urandom, $urandom_range(0, 99) < 55,
              $urandom_range(0, 49) == 0, $urandom_range(0, DEPTH + 20), "R2 data");
      end
      // registered mode, with the mode pin toggling afterwards (R8, R10)
      do_reset(1'b1);
      for (int i = 0; i < 70; i++) step(1, i, 0, 0, 0, "R2 data");
      for (int i = 0; i < 2000; i++) begin
         int bias = (i / 400) % 2 ? 75 : 35;
         if (i % 300 == 150) ae_sync = ~ae_sync;
         step($urandom_range(0, 99) < bias, $urandom, $urandom_range(0, 99) < 55,
              $urandom_range(0, 49) == 0, $urandom_range(0, DEPTH + 20), "R2 data");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule